// File: doc/BRIEF.md
# Gray-Coded Up/Down Pointer Counter

This block is a counter of parameterizable width that keeps two registers side by side: a plain binary count and a Gray-coded copy of that count. Both registers load on the same clock edge. The Gray register is not derived from the stored binary value. Instead, the next binary value is computed first. That value is then converted to Gray code by a generated chain of XOR gates, and the result is captured directly. Because of this, the two outputs always describe the same count, and the Gray output comes straight from flip-flops.

The block is meant to act as a pointer source for logic that crosses clock domains, for example the read or write side of an asynchronous FIFO. Only one Gray bit changes per step, so a pointer sampled in another clock domain is never more than one count off. An enable input gates counting. A direction input selects whether the count goes up or down. In both directions the count wraps modulo 2^WIDTH.

Top module: `gray_step_counter`

## Requirements
- R1: While `rst_n` is low, both `bin_q` and `gray_q` are all zeros. The reset is asynchronous on assertion and is released synchronously.
- R2: On a clock edge with `cnt_en` low, `bin_q` and `gray_q` keep their values. The value of `cnt_up` has no effect on that edge.
- R3: On a clock edge with `cnt_en` high and `cnt_up` = 1, `bin_q` becomes its previous value plus one, modulo 2^WIDTH.
- R4: On a clock edge with `cnt_en` high and `cnt_up` = 0, `bin_q` becomes its previous value minus one, modulo 2^WIDTH.
- R5: In every cycle, `gray_q` equals the Gray code of `bin_q`. For each bit k below the top bit, gray bit k is binary bit k+1 XOR binary bit k, and the top Gray bit equals the top binary bit. There is no cycle of lag between the two outputs.
- R6: After every enabled edge, `gray_q` differs from its value before that edge in exactly one bit position.
- R7: The wrap steps also change exactly one Gray bit, and the Gray value stays consistent with the binary value. Going up, all-ones wraps to zero. Going down, zero wraps to all-ones. The Gray code of all-ones is a single 1 in the top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both registers load on its rising edge |
| rst_n | input | 1 | Active-low reset; clears both registers |
| cnt_en | input | 1 | Count enable; high allows a step on this edge |
| cnt_up | input | 1 | Direction: 1 counts up, 0 counts down |
| bin_q | output | WIDTH | Registered binary count |
| gray_q | output | WIDTH | Registered Gray-coded count, in step with `bin_q` |

## Verification
The wrap-around and a change of direction can land in the same cycle. This happens when the count sits at zero or at all-ones and `cnt_up` flips on the very next enabled edge, so the counter wraps one way and immediately steps back. The bench provokes this by alternating direction right at both boundaries, with idle cycles mixed in. Each result is judged against a queued model count and its Gray code. The bench also checks that successive Gray values are exactly one bit apart.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;

  localparam int unsigned GC_DEFAULT_WIDTH = 6;

  // Direction encoding carried on cnt_up.
  typedef enum logic {
    GC_DOWN = 1'b0,
    GC_UP   = 1'b1
  } gc_dir_e;

endpackage

// File: rtl/gray_cnt_next.sv
// Next-state computation for the binary count.
module gray_cnt_next
  import gray_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = GC_DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] cur_bin,
  input  logic             step_en,
  input  logic             step_dir,
  output logic [WIDTH-1:0] nxt_bin
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  gc_dir_e dir;
  assign dir = gc_dir_e'(step_dir);

  always_comb begin
    nxt_bin = cur_bin;
    if (step_en) begin
      if (dir == GC_UP) nxt_bin = cur_bin + ONE;
      else              nxt_bin = cur_bin - ONE;
    end
  end

endmodule

// File: rtl/gray_cnt_b2g.sv
// Binary to Gray conversion built from a generated row of XOR gates.
module gray_cnt_b2g #(
  parameter int unsigned WIDTH = 6
) (
  input  logic [WIDTH-1:0] bin_in,
  output logic [WIDTH-1:0] gray_out
);

  localparam int unsigned TOP = WIDTH - 1;

  assign gray_out[TOP] = bin_in[TOP];

  generate
    for (genvar k = 0; k < TOP; k++) begin : g_xor
      assign gray_out[k] = bin_in[k+1] ^ bin_in[k];
    end
  endgenerate

endmodule

// File: rtl/gray_step_counter.sv
// Binary and Gray registers both loaded from the same next-state value.
module gray_step_counter
  import gray_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = GC_DEFAULT_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cnt_up,
  output logic [WIDTH-1:0] bin_q,
  output logic [WIDTH-1:0] gray_q
);

  logic [WIDTH-1:0] bin_r;
  logic [WIDTH-1:0] gray_r;
  logic [WIDTH-1:0] bin_d;
  logic [WIDTH-1:0] gray_d;
  logic             load_en;

  gray_cnt_next #(.WIDTH(WIDTH)) u_next (
    .cur_bin  (bin_r),
    .step_en  (cnt_en),
    .step_dir (cnt_up),
    .nxt_bin  (bin_d)
  );

  // Gray value is taken from the binary D-input, not from bin_r.
  gray_cnt_b2g #(.WIDTH(WIDTH)) u_b2g (
    .bin_in   (bin_d),
    .gray_out (gray_d)
  );

  assign load_en = cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_r  <= '0;
      gray_r <= '0;
    end else if (load_en) begin
      bin_r  <= bin_d;
      gray_r <= gray_d;
    end
  end

  assign bin_q  = bin_r;
  assign gray_q = gray_r;

  // R2: idle edges leave both registers untouched.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(bin_q) && $stable(gray_q)));

  // R3: an enabled up step adds one modulo 2^WIDTH.
  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt_up) |=> (bin_q == WIDTH'($past(bin_q) + WIDTH'(1))));

  // R4: an enabled down step subtracts one modulo 2^WIDTH.
  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_up) |=> (bin_q == WIDTH'($past(bin_q) - WIDTH'(1))));

  // R5: the two registers describe the same count in every cycle.
  p_in_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gray_q == (bin_q ^ (bin_q >> 1)));

  // R6: each enabled step flips exactly one Gray bit.
  p_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> ($countones(gray_q ^ $past(gray_q)) == 1));

  // R7: the downward wrap lands on all-ones with a lone top Gray bit.
  p_wrap_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_up && bin_q == '0) |=>
      (bin_q == '1 && gray_q == (WIDTH'(1) << (WIDTH - 1))));

endmodule

// File: tb/tb_gray_step_counter.sv
module tb_gray_step_counter;

  localparam int unsigned W = 6;
  localparam logic [W-1:0] MAXV = '1;

  logic         clk;
  logic         rst_n;
  logic         cnt_en;
  logic         cnt_up;
  logic [W-1:0] bin_q;
  logic [W-1:0] gray_q;

  int n_vec;
  int n_bad;
  bit done;

  logic [W-1:0] model_bin;
  logic [W-1:0] exp_bin_q[$];
  bit           exp_en_q[$];
  string        exp_tag_q[$];

  gray_step_counter #(.WIDTH(W)) dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .cnt_up (cnt_up),
    .bin_q  (bin_q),
    .gray_q (gray_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    logic [W-1:0] g;
    g[W-1] = b[W-1];
    for (int k = 0; k < W - 1; k++) g[k] = b[k] ^ b[k+1];
    return g;
  endfunction

  function automatic int hamming(input logic [W-1:0] a, input logic [W-1:0] b);
    int c = 0;
    for (int k = 0; k < W; k++) if (a[k] != b[k]) c++;
    return c;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected outcome.
  task automatic drive(input bit en, input bit up, input string tag);
    @(negedge clk);
    cnt_en = en;
    cnt_up = up;
    if (en) model_bin = up ? model_bin + 1'b1 : model_bin - 1'b1;
    exp_bin_q.push_back(model_bin);
    exp_en_q.push_back(en);
    exp_tag_q.push_back(tag);
  endtask

  // Monitor: samples 5 ns after each rising edge and compares.
  logic [W-1:0] prev_gray;
  initial begin
    prev_gray = '0;
    forever begin
      @(posedge clk);
      #5;
      if (exp_bin_q.size() > 0) begin
        logic [W-1:0] eb;
        bit           een;
        string        tg;
        eb  = exp_bin_q.pop_front();
        een = exp_en_q.pop_front();
        tg  = exp_tag_q.pop_front();
        n_vec++;
        if (bin_q !== eb) begin
          n_bad++;
          $display("FAIL %s bin_q actual=%0d expected=%0d", tg, bin_q, eb);
        end
        n_vec++;
        if (gray_q !== to_gray(eb)) begin
          n_bad++;
          $display("FAIL R5 gray_q actual=%b expected=%b", gray_q, to_gray(eb));
        end
        n_vec++;
        if (een && hamming(gray_q, prev_gray) != 1) begin
          n_bad++;
          $display("FAIL R6 gray distance actual=%0d expected=1 (%b -> %b)",
                   hamming(gray_q, prev_gray), prev_gray, gray_q);
        end else if (!een && gray_q !== prev_gray) begin
          n_bad++;
          $display("FAIL R2 gray_q actual=%b expected=%b", gray_q, prev_gray);
        end
      end
      prev_gray = gray_q;
    end
  end

  task automatic check_reset();
    n_vec++;
    if (bin_q !== '0 || gray_q !== '0) begin
      n_bad++;
      $display("FAIL R1 bin/gray actual=%0d/%b expected=0/0", bin_q, gray_q);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    cnt_en = 1'b0;
    rst_n  = 1'b0;
    #3;
    check_reset();
    repeat (2) @(negedge clk);
    check_reset();
    rst_n     = 1'b1;
    model_bin = '0;
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    cnt_en = 1'b0;
    cnt_up = 1'b1;
    model_bin = '0;
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;

    // R3 / R7: full upward lap plus wrap of all-ones to zero.
    for (int i = 0; i < 70; i++) drive(1'b1, 1'b1, "R3");
    // R2: idle with toggling direction.
    for (int i = 0; i < 6; i++) drive(1'b0, i[0], "R2");
    // R4 / R7: full downward lap plus wrap of zero to all-ones.
    for (int i = 0; i < 70; i++) drive(1'b1, 1'b0, "R4");

    // R7: reverse direction right at both boundaries.
    while (model_bin != '0) drive(1'b1, 1'b0, "R4");
    for (int i = 0; i < 8; i++) drive(1'b1, i[0], "R7");
    while (model_bin != MAXV) drive(1'b1, 1'b1, "R3");
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, ~i[0], "R7");
      drive(1'b0, i[0], "R2");
    end

    // Mixed traffic.
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 3);
      drive(r != 0, r[0], r == 0 ? "R2" : (r[0] ? "R3" : "R4"));
    end

    // R1: reset in mid-count, then count again.
    drive(1'b0, 1'b0, "R2");
    repeat (2) @(negedge clk);
    apply_reset();
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, "R4");
    drive(1'b0, 1'b1, "R2");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule